// File: doc/BRIEF.md
# Memory power-up and power-down sequencer

This block drives the two chip-enable levels of a pseudo-static memory through the slow phases of its life: the initialization that follows a valid supply, entry into deep power-down, and the exit back to service. The high-active enable is driven directly as `pwr_en`. The low-active enable is forced to its inactive (high) level by `sel_hold` whenever the sequencer owns it. When `sel_hold` is low, the access controller may drive that enable. All intervals are counted in clock cycles and set by parameters.

The access controller sees the sequencer through two signals only. `ready` permits normal accesses. `standby_ok` tells the sequencer that the memory is deselected and idle. A power-down request first withdraws `ready`. The high-active enable is then lowered only after standby is confirmed. Requests that arrive while a timed interval runs are remembered and served when that interval ends. Deep power-down loses the memory contents, so a `ready` that falls must be taken as data lost. The `BOOT_HIGH` parameter selects the power-up variant in which the high-active enable is held high. That variant inserts one forced power-down entry and exit before first use.

Top module: `mem_pwr_seq`

## Requirements
- R1: While reset is asserted, or while `supply_ok` is low, `pwr_en` sits at the boot level (0, or 1 when `BOOT_HIGH`=1), `sel_hold`=1, `ready`=0 and `busy`=1.
- R2: After the first clock edge that samples `supply_ok` high, `pwr_en` keeps its boot level for `T_BOOT` cycles.
- R3: `pwr_en` rises only after `sel_hold` has been 1 for `T_SETUP` cycles. On the default path it rises exactly `T_BOOT+T_SETUP` edges after the edge that first samples `supply_ok` high.
- R4: `ready` rises exactly `T_HOLD` cycles after `pwr_en` rises, with `sel_hold`=1 in between. While `ready`=1, `pwr_en`=1, `sel_hold`=0 and `busy`=0.
- R5: A power-down request drops `ready` on the next edge. `pwr_en` stays 1 for as long as `standby_ok` is 0.
- R6: Once `standby_ok` is seen, `sel_hold` is 1 for `T_SETUP` cycles before `pwr_en` falls.
- R7: `pwr_en` stays 0 for at least `T_PD_MIN` cycles. A wake request made during that interval is latched, and the rise starts when the interval ends (`pwr_en` high again `T_PD_MIN+T_SETUP` cycles after its fall).
- R8: After the minimum low interval without a pending wake, the block rests with `busy`=0 and `pwr_en`=0. A wake request then raises `pwr_en` `T_SETUP` cycles later, and `ready` follows after `T_HOLD` cycles.
- R9: A power-down request made during the post-rise hold is latched. `ready` never asserts, and the entry sequence follows the hold.
- R10: With `BOOT_HIGH`=1, `pwr_en` stays 1 for `T_BOOT+T_SETUP` cycles and then completes one power-down entry and exit before `ready` asserts.
- R11: `supply_ok` low returns the block to the R1 state on the next edge.
- R12: A wake request while `ready`=1 has no effect and is not remembered for a later power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply valid |
| pd_req | input | 1 | Deep power-down request (pulse or level) |
| wake_req | input | 1 | Power-down exit request (pulse or level) |
| standby_ok | input | 1 | Access controller confirms memory is deselected and idle |
| pwr_en | output | 1 | Level of the memory's high-active chip enable |
| sel_hold | output | 1 | 1 forces the low-active chip enable high; 0 hands it to the access controller |
| ready | output | 1 | Normal accesses permitted |
| busy | output | 1 | A sequence or timed interval is in progress |

## Verification
A wrong state or a mis-loaded interval counter shows at the ports as an enable edge that arrives early or late. The bench measures each interval as an exact edge count from the stimulus, so an off-by-one is caught at the first edge that differs. A stale or lost pending request appears as a rise of `pwr_en` while the block should rest, or as a memory left down. The bench watches for that over windows longer than every interval. An order violation between the two enables is caught by assertions within a cycle of the offending edge.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [3:0] {
    S_OFF      = 4'd0,
    S_BOOT     = 4'd1,
    S_RISE     = 4'd2,
    S_HOLD     = 4'd3,
    S_READY    = 4'd4,
    S_DRAIN    = 4'd5,
    S_PD_SETUP = 4'd6,
    S_PD_MIN   = 4'd7,
    S_DOWN     = 4'd8
  } pseq_state_t;

  function automatic int pseq_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Timer load for the interval that a state runs (length minus one).
  function automatic int pseq_load(input pseq_state_t s, input int t_boot,
                                   input int t_setup, input int t_hold,
                                   input int t_pd_min);
    case (s)
      S_BOOT:               return t_boot - 1;
      S_RISE, S_PD_SETUP:   return t_setup - 1;
      S_HOLD:               return t_hold - 1;
      S_PD_MIN:             return t_pd_min - 1;
      default:              return 0;
    endcase
  endfunction

endpackage

// File: rtl/pseq_req_latch.sv
module pseq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic pend_any
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q | req) & ~clr;
  end

  assign pend_any = pend_q | req;
endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import pseq_pkg::*;
#(
  parameter int T_BOOT    = 10000,
  parameter int T_SETUP   = 2,
  parameter int T_HOLD    = 70000,
  parameter int T_PD_MIN  = 20,
  parameter bit BOOT_HIGH = 1'b0,
  parameter int CNT_W     = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             standby_ok,
  input  logic             pd_any,
  input  logic             wake_any,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             pd_clr,
  output logic             wake_clr,
  output logic             pwr_en,
  output logic             sel_hold,
  output logic             ready,
  output logic             busy
);
  pseq_state_t state_q, state_d, boot_exit;
  logic        boot_lvl;
  logic        auto_q, auto_d;

  // Power-up variant: which level the high enable holds, and where boot leads.
  generate
    if (BOOT_HIGH) begin : g_boot_hi
      assign boot_lvl  = 1'b1;
      assign boot_exit = S_PD_SETUP;
    end else begin : g_boot_lo
      assign boot_lvl  = 1'b0;
      assign boot_exit = S_RISE;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_OFF:      if (supply_ok)  state_d = S_BOOT;
      S_BOOT:     if (tmr_done)   state_d = boot_exit;
      S_RISE:     if (tmr_done)   state_d = S_HOLD;
      S_HOLD:     if (tmr_done)   state_d = pd_any ? S_DRAIN : S_READY;
      S_READY:    if (pd_any)     state_d = S_DRAIN;
      S_DRAIN:    if (standby_ok) state_d = S_PD_SETUP;
      S_PD_SETUP: if (tmr_done)   state_d = S_PD_MIN;
      S_PD_MIN:   if (tmr_done)   state_d = (wake_any || auto_q) ? S_RISE : S_DOWN;
      S_DOWN:     if (wake_any)   state_d = S_RISE;
      default:                    state_d = S_OFF;
    endcase
    if (!supply_ok) state_d = S_OFF;
  end

  always_comb begin
    auto_d = auto_q;
    if (state_q == S_BOOT && tmr_done && BOOT_HIGH) auto_d = 1'b1;
    if (state_d == S_RISE || state_d == S_OFF)      auto_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      auto_q  <= auto_d;
    end
  end

  assign tmr_load = (state_d != state_q);
  assign tmr_val  = CNT_W'(pseq_load(state_d, T_BOOT, T_SETUP, T_HOLD, T_PD_MIN));

  always_comb begin
    case (state_q)
      S_OFF, S_BOOT:                       pwr_en = boot_lvl;
      S_PD_SETUP, S_HOLD, S_READY, S_DRAIN: pwr_en = 1'b1;
      default:                             pwr_en = 1'b0;
    endcase
  end

  assign sel_hold = !(state_q == S_READY || state_q == S_DRAIN);
  assign ready    = (state_q == S_READY);
  assign busy     = !(state_q == S_READY || state_q == S_DOWN);
  assign pd_clr   = (state_q == S_PD_SETUP) || (state_q == S_PD_MIN) ||
                    (state_q == S_DOWN) || (state_q == S_OFF);
  assign wake_clr = (state_q == S_OFF) || (state_q == S_BOOT) || (state_q == S_RISE) ||
                    (state_q == S_HOLD) || (state_q == S_READY) || (state_q == S_DRAIN);

  // R3: high enable rises only with the low enable already forced high
  a_r3_rise_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) && $past(supply_ok) |-> sel_hold && $past(sel_hold));

  // R4: ready implies a fully powered, released memory
  a_r4_ready_state: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> pwr_en && !sel_hold && !busy);

  // R5: no entry without standby confirmation
  a_r5_standby_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DRAIN) && !standby_ok && supply_ok |=> pwr_en);

  // R6: low enable forced high before the high enable falls
  a_r6_fall_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) && $past(supply_ok) |-> sel_hold && $past(sel_hold));

  // R7: minimum low interval is not cut short
  a_r7_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PD_MIN) && !tmr_done && supply_ok |=> !pwr_en);

  // R9: a request pending at hold end keeps ready low
  a_r9_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HOLD) && tmr_done && pd_any && supply_ok |=> !ready);

  // R11: supply loss withdraws ready at once
  a_r11_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !ready && busy);
endmodule

// File: rtl/mem_pwr_seq.sv
module mem_pwr_seq
  import pseq_pkg::*;
#(
  parameter int T_BOOT    = 10000,
  parameter int T_SETUP   = 2,
  parameter int T_HOLD    = 70000,
  parameter int T_PD_MIN  = 20,
  parameter bit BOOT_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic pd_req,
  input  logic wake_req,
  input  logic standby_ok,
  output logic pwr_en,
  output logic sel_hold,
  output logic ready,
  output logic busy
);
  localparam int MAX_T = pseq_max(pseq_max(T_BOOT, T_SETUP), pseq_max(T_HOLD, T_PD_MIN));
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             pd_any, wake_any, pd_clr, wake_clr;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  pseq_req_latch u_pd_latch (
    .clk(clk), .rst_n(rst_n), .req(pd_req), .clr(pd_clr), .pend_any(pd_any));

  pseq_req_latch u_wake_latch (
    .clk(clk), .rst_n(rst_n), .req(wake_req), .clr(wake_clr), .pend_any(wake_any));

  pseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done));

  pseq_ctrl #(
    .T_BOOT(T_BOOT), .T_SETUP(T_SETUP), .T_HOLD(T_HOLD),
    .T_PD_MIN(T_PD_MIN), .BOOT_HIGH(BOOT_HIGH), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .standby_ok(standby_ok),
    .pd_any(pd_any), .wake_any(wake_any), .tmr_done(tmr_done),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .pd_clr(pd_clr), .wake_clr(wake_clr),
    .pwr_en(pwr_en), .sel_hold(sel_hold), .ready(ready), .busy(busy));
endmodule

// File: tb/test_mem_pwr_seq.sv
module test_mem_pwr_seq;
  localparam int TB  = 20;
  localparam int TS  = 2;
  localparam int TH  = 40;
  localparam int TPD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, supply_bh = 1'b0;
  logic pd_req = 1'b0, wake_req = 1'b0, standby_ok = 1'b0;
  logic pwr_en, sel_hold, ready, busy;
  logic bh_pwr_en, bh_sel_hold, bh_ready, bh_busy;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  mem_pwr_seq #(.T_BOOT(TB), .T_SETUP(TS), .T_HOLD(TH), .T_PD_MIN(TPD), .BOOT_HIGH(1'b0))
  i_mem_pwr_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req),
    .wake_req(wake_req), .standby_ok(standby_ok), .pwr_en(pwr_en),
    .sel_hold(sel_hold), .ready(ready), .busy(busy));

  mem_pwr_seq #(.T_BOOT(TB), .T_SETUP(TS), .T_HOLD(TH), .T_PD_MIN(TPD), .BOOT_HIGH(1'b1))
  i_mem_pwr_seq_bh (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_bh), .pd_req(pd_req),
    .wake_req(wake_req), .standby_ok(standby_ok), .pwr_en(bh_pwr_en),
    .sel_hold(bh_sel_hold), .ready(bh_ready), .busy(bh_busy));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return pwr_en;
      1: return ready;
      2: return busy;
      3: return bh_pwr_en;
      default: return bh_ready;
    endcase
  endfunction

  // Counts falling edges until the selected output reaches lvl.
  task automatic wait_lvl(input int sel, input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sig(sel) !== lvl && n < 2000);
  endtask

  task automatic pulse_pd();
    pd_req = 1'b1; @(negedge clk); pd_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 pwr_en", pwr_en, 0);
    chk("R1 sel_hold", sel_hold, 1);
    chk("R1 ready", ready, 0);
    chk("R1 busy", busy, 1);
    chk("R1 boot-high pwr_en", bh_pwr_en, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no supply pwr_en", pwr_en, 0);
  endtask

  task automatic t_boot_high();
    int n;
    supply_bh = 1'b1;
    wait_lvl(3, 1'b0, n);
    chk("R10 high boot length", n, TB + TS + 1);
    chk("R10 ready low", bh_ready, 0);
    wait_lvl(3, 1'b1, n);
    chk("R10 forced low interval", n, TPD + TS);
    chk("R10 ready low after exit", bh_ready, 0);
    wait_lvl(4, 1'b1, n);
    chk("R10 ready after hold", n, TH);
  endtask

  task automatic t_powerup();
    int n;
    supply_ok = 1'b1;
    @(negedge clk);
    chk("R2 boot level held", pwr_en, 0);
    wait_lvl(0, 1'b1, n);
    chk("R2 R3 rise edge count", n + 1, TB + TS + 1);
    chk("R4 sel_hold during hold", sel_hold, 1);
    chk("R4 ready low during hold", ready, 0);
    wait_lvl(1, 1'b1, n);
    chk("R4 hold length", n, TH);
    chk("R4 released", sel_hold, 0);
    chk("R4 not busy", busy, 0);
  endtask

  task automatic t_wake_ignored();
    pulse_wake();
    repeat (5) @(negedge clk);
    chk("R12 ready kept", ready, 1);
    chk("R12 pwr_en kept", pwr_en, 1);
  endtask

  task automatic t_pd_entry();
    int n;
    standby_ok = 1'b0;
    pulse_pd();
    chk("R5 ready drops", ready, 0);
    repeat (8) @(negedge clk);
    chk("R5 waits for standby", pwr_en, 1);
    chk("R5 busy while draining", busy, 1);
    standby_ok = 1'b1;
    wait_lvl(0, 1'b0, n);
    chk("R6 setup before fall", n, TS + 1);
    chk("R6 sel_hold at fall", sel_hold, 1);
    pulse_wake();
    wait_lvl(0, 1'b1, n);
    chk("R7 low interval with wake", n + 1, TPD + TS);
    wait_lvl(1, 1'b1, n);
    chk("R7 ready after exit", n, TH);
  endtask

  task automatic t_pd_down();
    int n, hi;
    pulse_pd();
    wait_lvl(0, 1'b0, n);
    chk("R6 fall with standby given", n + 1, TS + 2);
    wait_lvl(2, 1'b0, n);
    chk("R8 rest after minimum low", n, TPD);
    hi = 0;
    repeat (12) begin
      @(negedge clk);
      if (pwr_en) hi = 1;
    end
    chk("R12 no stale wake", hi, 0);
    chk("R8 resting not busy", busy, 0);
    pulse_wake();
    wait_lvl(0, 1'b1, n);
    chk("R8 wake rise", n + 1, TS + 1);
    wait_lvl(1, 1'b1, n);
    chk("R8 ready after wake", n, TH);
  endtask

  task automatic t_pd_in_hold();
    int n, seen;
    pulse_pd();
    wait_lvl(2, 1'b0, n);
    pulse_wake();
    wait_lvl(0, 1'b1, n);
    repeat (3) @(negedge clk);
    pulse_pd();
    seen = 0;
    repeat (TH + TS + TPD + 20) begin
      @(negedge clk);
      if (ready) seen = 1;
    end
    chk("R9 ready never asserted", seen, 0);
    chk("R9 entered power-down", pwr_en, 0);
    chk("R9 resting", busy, 0);
  endtask

  task automatic t_supply_loss();
    int n;
    pulse_wake();
    wait_lvl(1, 1'b1, n);
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R11 ready dropped", ready, 0);
    chk("R11 busy", busy, 1);
    chk("R11 pwr_en boot level", pwr_en, 0);
    chk("R11 sel_hold", sel_hold, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_boot_high();
    t_powerup();
    t_wake_ignored();
    t_pd_entry();
    t_pd_down();
    t_pd_in_hold();
    t_supply_loss();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule